// File: doc/BRIEF.md
# Vectored Interrupt Controller, 64 Sources

This block gathers 64 request lines and selects one to present to a processor, which sees it as a single interrupt line. Software sets up each source through a small register bus. Each source has a configuration word that makes it edge-triggered or level-triggered and gives it a 4-bit priority. Enables are changed through separate set-only and clear-only registers, one of each for the lower 32 and the upper 32 sources, so no read-modify-write is needed.

To service an interrupt, the handler reads the vector register. That read returns the winning source number and puts the source in service. While a source is in service, only sources of strictly higher priority can raise the line. A write to the end-of-interrupt register ends service. When nothing qualifies, the vector read returns 64, which software treats as spurious. A soft-reset write returns all control state to zero. A global enable gates the output line.

Top module: `vic64_ctrl`

## Requirements
- R1: After `rst_n` is released, every source is disabled, every configuration word is 0, the global enable is 0, `irq_o` is low and a vector read returns 64.
- R2: A write to 0x08 sets the enable of source n for each bit n written as 1. A write to 0x0C does the same for source 32+n. Bits written as 0 change nothing.
- R3: A write to 0x10 clears the enable of source n for each bit n written as 1. A write to 0x14 does the same for source 32+n. Bits written as 0 change nothing.
- R4: The configuration word of source n sits at 0x100 + 8·n. Bit 4 set selects edge mode and bit 4 clear selects level mode. Bits 3:0 hold the priority level. The word reads back as written.
- R5: An edge-mode source becomes pending on a 0→1 change of its input. It stays pending after the input falls. It stops being pending only when an end-of-interrupt write retires it from service.
- R6: A level-mode source is pending exactly while its input is high.
- R7: Only sources that are both enabled and pending compete. The highest level wins, and on equal levels the lower source number wins. A read of 0x18 returns the winner's number in bits 6:0, or 64 when no source qualifies.
- R8: A vector read that returns a valid number puts that source in service at its level. Until service ends, only sources with a strictly higher level qualify, for both `irq_o` and the vector. A qualifying read moves service to the new source.
- R9: Any write to 0x1C, whatever the data, ends service.
- R10: `irq_o` is high exactly when bit 0 of the register at 0x20 is set and some source qualifies. Bit 0 of 0x20 reads back. Vector reads are not gated by this bit.
- R11: A write to 0x00 with bit 0 set clears all enables, all configuration words, all edge-pending flags, the global enable and the in-service state. A write to 0x00 with bit 0 clear has no effect.
- R12: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`. Addresses 0x00 through 0x14, 0x1C, and addresses with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 64 | Request lines, synchronous to `clk` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The directed tests target ties at equal level. A design that let the higher number win would return 10 instead of 3. The tests also check that an equal-level source cannot preempt the one in service: a wrong design would raise `irq_o` again right after the vector read. Other directed cases cover an edge request whose input has already fallen by the time it is serviced, a soft-reset write with bit 0 clear that must leave everything as it was, and a vector read with the global enable off. A design that cleared edge-pending on the vector read instead of at end of interrupt, or that decoded the high-bank disable register as the low bank, would differ from the bench model in the random phase. That phase mixes enables, configuration rewrites, sparse input patterns and nested service.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // register byte offsets
  localparam int OFS_SRST    = 'h000;
  localparam int OFS_EN_LO   = 'h008;
  localparam int OFS_DIS_LO  = 'h010;
  localparam int OFS_VEC     = 'h018;
  localparam int OFS_EOI     = 'h01C;
  localparam int OFS_GENA    = 'h020;
  localparam int CFG_BASE    = 'h100;
  localparam int CFG_STRIDE  = 8;
  localparam int BANK_BITS   = 32;
  localparam int EDGE_BIT    = 4;

  // offset of the enable/disable word that covers source idx
  function automatic int bank_ofs(int base, int idx);
    return base + 4 * (idx / BANK_BITS);
  endfunction

  function automatic bit is_cfg_addr(int addr, int nsrc);
    return addr >= CFG_BASE && addr < CFG_BASE + CFG_STRIDE * nsrc
           && (addr % CFG_STRIDE) == 0;
  endfunction

  function automatic int cfg_slot(int addr);
    return (addr - CFG_BASE) / CFG_STRIDE;
  endfunction

  // a contender displaces the reference only with a strictly higher level
  function automatic bit outranks(int cand_lvl, int ref_lvl);
    return cand_lvl > ref_lvl;
  endfunction
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int NSRC  = 64,
  parameter int LVL_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic [NSRC-1:0]            en_set,
  input  logic [NSRC-1:0]            en_clr,
  input  logic [NSRC-1:0]            cfg_we,
  input  logic [LVL_W:0]             cfg_wdata,
  input  logic [NSRC-1:0]            ack_clr,
  input  logic [NSRC-1:0]            irq_src,
  output logic [NSRC-1:0]            enabled,
  output logic [NSRC-1:0]            edge_mode,
  output logic [NSRC-1:0][LVL_W-1:0] lvl,
  output logic [NSRC-1:0]            pending
);
  logic [NSRC-1:0] src_prev;
  logic [NSRC-1:0] src_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= irq_src;
  end

  assign src_rise = irq_src & ~src_prev;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic             en_q;
    logic             edge_q;
    logic [LVL_W-1:0] lvl_q;
    logic             pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; edge_q <= 1'b0; lvl_q <= '0; pend_q <= 1'b0;
      end else if (soft_rst) begin
        en_q <= 1'b0; edge_q <= 1'b0; lvl_q <= '0; pend_q <= 1'b0;
      end else begin
        if (en_set[gi])      en_q <= 1'b1;
        else if (en_clr[gi]) en_q <= 1'b0;
        if (cfg_we[gi]) begin
          edge_q <= cfg_wdata[LVL_W];
          lvl_q  <= cfg_wdata[LVL_W-1:0];
        end
        // a fresh edge wins over a retirement in the same cycle
        pend_q <= (pend_q & ~ack_clr[gi]) | (edge_q & src_rise[gi]);
      end
    end

    assign enabled[gi]   = en_q;
    assign edge_mode[gi] = edge_q;
    assign lvl[gi]       = lvl_q;
    assign pending[gi]   = edge_q ? pend_q : irq_src[gi];
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC  = 64,
  parameter int LVL_W = 4,
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            cand,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl,
  input  logic                       thr_valid,
  input  logic [LVL_W-1:0]           thr_lvl,
  output logic                       sel_valid,
  output logic [IDW-1:0]             sel_idx,
  output logic [LVL_W-1:0]           sel_lvl
);
  import vic_pkg::*;

  // ascending scan: a later source replaces the best only if strictly higher
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i]
          && (!thr_valid || outranks(int'(lvl[i]), int'(thr_lvl)))
          && (!sel_valid || outranks(int'(lvl[i]), int'(sel_lvl)))) begin
        sel_valid = 1'b1;
        sel_idx   = IDW'(i);
        sel_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/vic64_ctrl.sv
module vic64_ctrl #(
  parameter int NSRC   = 64,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_o
);
  import vic_pkg::*;
  localparam int IDW   = $clog2(NSRC);
  localparam int VEC_W = IDW + 1;

  // named internal events
  logic                       soft_rst, eoi_hit, gena_wr, vec_rd, cfg_hit;
  logic [IDW-1:0]             cfg_idx;
  logic [NSRC-1:0]            en_set, en_clr, cfg_we, ack_clr;
  logic [NSRC-1:0]            enabled, edge_mode, pending, cand;
  logic [NSRC-1:0][LVL_W-1:0] lvl;
  logic                       sel_valid;
  logic [IDW-1:0]             sel_idx;
  logic [LVL_W-1:0]           sel_lvl;
  logic                       gena_q, insvc_valid;
  logic [IDW-1:0]             insvc_id;
  logic [LVL_W-1:0]           insvc_lvl;
  logic [VEC_W-1:0]           vec_val;
  logic [DATA_W-1:0]          rd_mux;

  assign soft_rst = bus_wr && bus_addr == ADDR_W'(OFS_SRST) && bus_wdata[0];
  assign eoi_hit  = bus_wr && bus_addr == ADDR_W'(OFS_EOI);
  assign gena_wr  = bus_wr && bus_addr == ADDR_W'(OFS_GENA);
  assign vec_rd   = bus_rd && bus_addr == ADDR_W'(OFS_VEC);
  assign cfg_hit  = is_cfg_addr(int'(bus_addr), NSRC);
  assign cfg_idx  = IDW'(cfg_slot(int'(bus_addr)));

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_dec
    assign en_set[gi]  = bus_wr && bus_wdata[gi % BANK_BITS]
                         && bus_addr == ADDR_W'(bank_ofs(OFS_EN_LO, gi));
    assign en_clr[gi]  = bus_wr && bus_wdata[gi % BANK_BITS]
                         && bus_addr == ADDR_W'(bank_ofs(OFS_DIS_LO, gi));
    assign cfg_we[gi]  = bus_wr && cfg_hit && cfg_idx == IDW'(gi);
    assign ack_clr[gi] = eoi_hit && insvc_valid && insvc_id == IDW'(gi);
  end

  vic_src_bank #(.NSRC(NSRC), .LVL_W(LVL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .en_set(en_set), .en_clr(en_clr), .cfg_we(cfg_we),
    .cfg_wdata(bus_wdata[LVL_W:0]), .ack_clr(ack_clr), .irq_src(irq_src),
    .enabled(enabled), .edge_mode(edge_mode), .lvl(lvl), .pending(pending)
  );

  assign cand = enabled & pending;

  vic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .cand(cand), .lvl(lvl), .thr_valid(insvc_valid), .thr_lvl(insvc_lvl),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_lvl(sel_lvl)
  );

  assign irq_o   = gena_q && sel_valid;
  assign vec_val = sel_valid ? {1'b0, sel_idx} : VEC_W'(NSRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gena_q <= 1'b0; insvc_valid <= 1'b0; insvc_id <= '0; insvc_lvl <= '0;
    end else if (soft_rst) begin
      gena_q <= 1'b0; insvc_valid <= 1'b0; insvc_id <= '0; insvc_lvl <= '0;
    end else begin
      if (gena_wr) gena_q <= bus_wdata[0];
      if (vec_rd && sel_valid) begin
        insvc_valid <= 1'b1;
        insvc_id    <= sel_idx;
        insvc_lvl   <= sel_lvl;
      end
      if (eoi_hit) insvc_valid <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_VEC))
      rd_mux = DATA_W'(vec_val);
    else if (bus_addr == ADDR_W'(OFS_GENA))
      rd_mux = DATA_W'(gena_q);
    else if (cfg_hit)
      rd_mux = DATA_W'({edge_mode[cfg_idx], lvl[cfg_idx]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NSRC   = 64,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDW   = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              gena_q,
  input logic              sel_valid,
  input logic [IDW-1:0]    sel_idx,
  input logic [LVL_W-1:0]  sel_lvl,
  input logic              insvc_valid,
  input logic [LVL_W-1:0]  insvc_lvl,
  input logic [NSRC-1:0]   enabled,
  input logic [NSRC-1:0]   pending,
  input logic              vec_rd,
  input logic              eoi_hit,
  input logic              soft_rst,
  input logic [DATA_W-1:0] bus_rdata
);
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gena_q && sel_valid));

  p_winner_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (enabled[sel_idx] && pending[sel_idx]));

  p_strict_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_valid && sel_valid) |-> (sel_lvl > insvc_lvl));

  p_empty_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !sel_valid) |=> (bus_rdata == DATA_W'(NSRC)));

  p_eoi_ends_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !insvc_valid);

  p_soft_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (enabled == '0 && !gena_q && !insvc_valid && !irq_o));

  p_vector_enters_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && sel_valid && !eoi_hit && !soft_rst) |=> insvc_valid);
endmodule

bind vic64_ctrl vic_checker #(.NSRC(NSRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .gena_q(gena_q),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_lvl(sel_lvl),
  .insvc_valid(insvc_valid), .insvc_lvl(insvc_lvl),
  .enabled(enabled), .pending(pending), .vec_rd(vec_rd),
  .eoi_hit(eoi_hit), .soft_rst(soft_rst), .bus_rdata(bus_rdata)
);

// File: tb/vic64_ctrl_test.sv
module vic64_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [63:0] m_en = '0, m_edge = '0, m_pend = '0, m_in = '0;
  int          m_lvl [64];
  bit          m_gena = 1'b0, m_sv = 1'b0;
  int          m_svid = 0, m_svlvl = 0;

  always #5 clk = ~clk;

  vic64_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_o(irq_o)
  );

  function automatic bit m_pending(int i);
    return m_edge[i] ? m_pend[i] : m_in[i];
  endfunction

  // expected winner, -1 when none
  function automatic int exp_sel();
    int best = -1;
    for (int i = 0; i < 64; i++) begin
      if (m_en[i] && m_pending(i) && (!m_sv || m_lvl[i] > m_svlvl)
          && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_addr = 12'(addr); bus_wdata = 32'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    bus_addr = 12'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    irq_src = v;
    m_pend = m_pend | (v & ~m_in & m_edge);
    m_in = v;
    @(negedge clk);
  endtask

  task automatic cfg(input int n, input bit edge_m, input int lv);
    wr('h100 + 8 * n, (int'(edge_m) << 4) | lv);
    m_edge[n] = edge_m; m_lvl[n] = lv;
  endtask

  task automatic enable(input bit hi, input int mask);
    wr(hi ? 'h0C : 'h08, mask);
    for (int i = 0; i < 32; i++) if (mask[i]) m_en[(hi ? 32 : 0) + i] = 1'b1;
  endtask

  task automatic disable_src(input bit hi, input int mask);
    wr(hi ? 'h14 : 'h10, mask);
    for (int i = 0; i < 32; i++) if (mask[i]) m_en[(hi ? 32 : 0) + i] = 1'b0;
  endtask

  task automatic set_gena(input bit g);
    wr('h20, int'(g)); m_gena = g;
  endtask

  task automatic eoi(input int data);
    wr('h1C, data);
    if (m_sv) m_pend[m_svid] = 1'b0;
    m_sv = 1'b0;
  endtask

  task automatic vec_check(input string req);
    int e, v, got;
    e = exp_sel();
    v = (e < 0) ? 64 : e;
    rd('h18, got);
    check(got == v, req, got, v);
    if (e >= 0) begin m_sv = 1'b1; m_svid = e; m_svlvl = m_lvl[e]; end
  endtask

  task automatic irq_check(input string req);
    bit e;
    e = m_gena && (exp_sel() >= 0);
    check(irq_o == e, req, irq_o, e);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 read-zero addresses
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    vec_check("R1 vector after reset");
    rd('h20, d); check(d == 0, "R1 gena after reset", d, 0);
    rd('h100 + 8 * 17, d); check(d == 0, "R1 cfg after reset", d, 0);
    rd('h08, d); check(d == 0, "R12 write-only reads zero", d, 0);
    rd('h1C, d); check(d == 0, "R12 eoi reads zero", d, 0);

    // R4 configuration readback
    cfg(5, 1'b0, 3);
    cfg(40, 1'b1, 7);
    rd('h100 + 8 * 5, d);  check(d == 3, "R4 cfg level src5", d, 3);
    rd('h100 + 8 * 40, d); check(d == 'h17, "R4 cfg edge src40", d, 'h17);
    // R2 enables in both halves
    enable(1'b0, 32'h20);
    enable(1'b1, 32'h100);
    set_gena(1'b1);
    rd('h20, d); check(d == 1, "R10 gena readback", d, 1);

    // R6 level follows input
    set_src(64'h20);
    irq_check("R6 level high raises irq");
    check(irq_o == 1'b1, "R2 enabled level source", irq_o, 1);
    set_src(64'h0);
    check(irq_o == 1'b0, "R6 level low drops irq", irq_o, 0);

    // R5 edge latches after input falls
    set_src(64'h1 << 40);
    set_src(64'h0);
    check(irq_o == 1'b1, "R5 edge stays pending", irq_o, 1);
    vec_check("R7 vector for edge src40");
    check(irq_o == 1'b0, "R8 in-service masks itself", irq_o, 0);
    eoi(32'hDEAD);
    check(irq_o == 1'b0, "R5 edge cleared by eoi", irq_o, 0);
    vec_check("R9 vector empty after eoi");

    // R7 tie goes to lower number
    cfg(3, 1'b0, 6); cfg(10, 1'b0, 6); cfg(60, 1'b0, 9);
    enable(1'b0, 32'h408);
    set_src((64'h1 << 3) | (64'h1 << 10));
    vec_check("R7 tie lowest number");
    set_src((64'h1 << 3) | (64'h1 << 10) | (64'h1 << 5));
    irq_check("R8 lower level blocked");
    check(irq_o == 1'b0, "R8 equal/lower no preempt", irq_o, 0);
    vec_check("R8 vector empty while in service");
    enable(1'b1, 32'h1000_0000);
    set_src((64'h1 << 3) | (64'h1 << 10) | (64'h1 << 60));
    check(irq_o == 1'b1, "R8 higher level preempts", irq_o, 1);
    vec_check("R8 preempting vector 60");
    eoi(0);
    // R3 disable low bank bit 3
    disable_src(1'b0, 32'h8);
    disable_src(1'b1, 32'h1000_0000);
    vec_check("R3 disabled source skipped");
    eoi(0);

    // R10 global enable gates irq but not vector
    set_gena(1'b0);
    check(irq_o == 1'b0, "R10 gena off", irq_o, 0);
    vec_check("R10 vector ungated");
    eoi(0);
    set_gena(1'b1);
    irq_check("R10 gena on");

    // R11 soft reset: bit0 clear does nothing, bit0 set clears
    wr('h00, 32'hFFFE);
    rd('h20, d); check(d == 1, "R11 no-op soft reset keeps gena", d, 1);
    rd('h100 + 8 * 60, d); check(d == 9, "R11 no-op keeps cfg", d, 9);
    wr('h00, 1);
    m_en = '0; m_edge = '0; m_pend = '0; m_gena = 1'b0; m_sv = 1'b0;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    check(irq_o == 1'b0, "R11 irq after soft reset", irq_o, 0);
    rd('h20, d); check(d == 0, "R11 gena cleared", d, 0);
    rd('h100 + 8 * 40, d); check(d == 0, "R11 cfg cleared", d, 0);
    set_gena(1'b1);
    vec_check("R11 enables cleared");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: cfg(int'($urandom_range(0, 63)), 1'($urandom), int'($urandom_range(0, 15)));
        2: enable(1'($urandom), int'($urandom & $urandom));
        3: disable_src(1'($urandom), int'($urandom & $urandom & $urandom));
        4, 5: set_src({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        6, 7: vec_check("R7 random vector");
        8: eoi(int'($urandom));
        default: begin
          if ($urandom_range(0, 3) == 0) set_gena(1'($urandom));
          else begin
            int n;
            n = int'($urandom_range(0, 63));
            rd('h100 + 8 * n, d);
            check(d == ((int'(m_edge[n]) << 4) | m_lvl[n]), "R4 random readback",
                  d, (int'(m_edge[n]) << 4) | m_lvl[n]);
          end
        end
      endcase
      irq_check("R10 random irq");
    end

    done = 1'b1;
    summary();
  end
endmodule